// File: doc/BRIEF.md
# Framebuffer VGA Scan-Out Address Generator

This block produces the horizontal and vertical sync pulses for a 640x480 display driven from a 25 MHz pixel clock (800 clocks per line, 525 lines per frame). While the beam is inside the visible area it also emits the SRAM byte address of the pixel to show, for a 256x240 image with one byte per pixel. Each byte holds two bits for each of red, green and blue. A colour-enable output gates the external DAC, so nothing reaches the screen during blanking.

The address is built from three parts. The top bit is the bank bit. The middle byte is the image row, which is the scanline number halved, so every row appears on two scanlines. The low byte is the column step. A fractional accumulator advances the column step at two fifths of the pixel clock, which gives 256 steps per line. In high-resolution mode it advances at four fifths of the pixel clock, which gives 512 steps per line. These 512 steps follow an interleaved order: bit 3 of the low byte toggles on every step, the counter skips over that bit, and the bank bit flips at the middle of the line.

A fast mode keeps every odd scanline black. The bank, high-resolution and fast inputs are captured only once per frame, at the first clock of vertical blanking, so a frame is never split between two buffers.

Top module: `fb_scan_gen`

## Requirements
- R1: `hsyncN` is low for exactly H_SYNC clocks of every H_TOTAL-clock line, starting H_ACTIVE+H_FP clocks after the line start. It is registered, so it appears one clock after the line position it belongs to.
- R2: `vsyncN` is low for exactly V_SYNC whole lines, starting at line V_ACTIVE+V_FP. It changes only together with a line boundary.
- R3: `colorEn` is high only when the horizontal position is below H_ACTIVE and the line is below V_ACTIVE. It is low throughout horizontal and vertical blanking, including both sync pulses.
- R4: In low-resolution mode, at active pixel p of line v, the output `vgaAddr` is {bank, v/2, floor(p*2/5)}. In this order, bit 16 is the bank, bits 15:8 are the row and bits 7:0 are the column.
- R5: In high-resolution mode, let k = floor(p*4/5), HALF = H_ACTIVE*2/5 and j = k mod HALF. The column byte is {j[7:4], j[0], j[3:1]}, so bit 3 carries the step parity. The bank bit is the captured bank XOR (k >= HALF).
- R6: In fast mode, `colorEn` stays low on odd active lines. Addresses are still generated on those lines.
- R7: The bank, high-resolution and fast inputs are captured on the last clock of line V_ACTIVE-1. They take effect from the next position. Changes at any other time have no effect on the outputs before that capture.
- R8: During reset, `hsyncN` and `vsyncN` are 1, `colorEn` is 0 and `vgaAddr` is 0. All captured selections are 0. The first clock after reset outputs position (0,0).
- R9: `vgaAddr` is 0 whenever the position is outside the active area.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| bankSel | input | 1 | Display bank for the next frame |
| hiResSel | input | 1 | Selects 512-step interleaved addressing for the next frame |
| fastSel | input | 1 | Blanks odd scanlines in the next frame |
| vgaAddr | output | 1+ROW_W+COL_W | Framebuffer byte address |
| colorEn | output | 1 | Enables the colour DAC |
| hsyncN | output | 1 | Horizontal sync, active low |
| vsyncN | output | 1 | Vertical sync, active low |

## Verification
The counters have no port of their own, so a wrong line or frame count first shows up as a sync pulse in the wrong place, or as a `colorEn` window that is shifted or has the wrong length, within one line or one frame. A wrong accumulator phase shows up on the very next active line: the column byte repeats a value or skips one, and in high-resolution mode bit 3 stops toggling or the bank flip moves away from the middle of the line. A capture made at the wrong time shows up as a bank or mode change in the middle of a frame, within the frame in which the input was changed.

// File: rtl/fb_scan_pkg.sv
package fb_scan_pkg;
  // Per-clock position strobes passed from the control counters to the datapath
  typedef struct packed {
    logic lineEnd;     // last clock of a line
    logic hActive;     // horizontal position inside the visible area
    logic vActive;     // line inside the visible area
    logic oddLine;     // scanline number is odd
    logic hSyncOn;     // horizontal sync window
    logic vSyncOn;     // vertical sync window
    logic frameLatch;  // last clock of the last visible line
  } scanStrobes_t;
endpackage

// File: rtl/fb_scan_ctrl.sv
module fb_scan_ctrl
  import fb_scan_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int ROW_W    = 8
) (
  input  logic               clk,
  input  logic               rst,
  output scanStrobes_t       strobes,
  output logic [ROW_W-1:0]   rowIdx
);
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int HCW = $clog2(H_TOTAL);
  localparam int VCW = $clog2(V_TOTAL);
  localparam logic [HCW-1:0] H_LAST   = HCW'(H_TOTAL - 1);
  localparam logic [HCW-1:0] H_VIS    = HCW'(H_ACTIVE);
  localparam logic [HCW-1:0] HS_BEG   = HCW'(H_ACTIVE + H_FP);
  localparam logic [HCW-1:0] HS_END   = HCW'(H_ACTIVE + H_FP + H_SYNC);
  localparam logic [VCW-1:0] V_LAST   = VCW'(V_TOTAL - 1);
  localparam logic [VCW-1:0] V_VIS    = VCW'(V_ACTIVE);
  localparam logic [VCW-1:0] V_VISEND = VCW'(V_ACTIVE - 1);
  localparam logic [VCW-1:0] VS_BEG   = VCW'(V_ACTIVE + V_FP);
  localparam logic [VCW-1:0] VS_END   = VCW'(V_ACTIVE + V_FP + V_SYNC);

  logic [HCW-1:0] hCnt;
  logic [VCW-1:0] vCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (hCnt == H_LAST) begin
      hCnt <= '0;
      vCnt <= (vCnt == V_LAST) ? '0 : vCnt + VCW'(1);
    end else begin
      hCnt <= hCnt + HCW'(1);
    end
  end

  always_comb begin
    strobes.lineEnd    = (hCnt == H_LAST);
    strobes.hActive    = (hCnt < H_VIS);
    strobes.vActive    = (vCnt < V_VIS);
    strobes.oddLine    = vCnt[0];
    strobes.hSyncOn    = (hCnt >= HS_BEG) && (hCnt < HS_END);
    strobes.vSyncOn    = (vCnt >= VS_BEG) && (vCnt < VS_END);
    strobes.frameLatch = (hCnt == H_LAST) && (vCnt == V_VISEND);
    rowIdx             = ROW_W'(vCnt >> 1);
  end

  // R2
  vsync_line_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(strobes.lineEnd) |-> $stable(strobes.vSyncOn));

  // R1
  hsync_in_blank_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.hSyncOn |-> !strobes.hActive);
endmodule

// File: rtl/fb_scan_dpath.sv
module fb_scan_dpath
  import fb_scan_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int COL_W    = 8,
  parameter int ROW_W    = 8,
  parameter int TOG_BIT  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  scanStrobes_t              strobes,
  input  logic [ROW_W-1:0]          rowIdx,
  input  logic                      bankSel,
  input  logic                      hiResSel,
  input  logic                      fastSel,
  output logic [ROW_W+COL_W:0]      vgaAddr,
  output logic                      colorEn,
  output logic                      hsyncN,
  output logic                      vsyncN
);
  localparam int ADDR_W = 1 + ROW_W + COL_W;
  localparam int STEP_W = COL_W + 2;
  localparam logic [STEP_W-1:0] HALF_C = STEP_W'(H_ACTIVE * 2 / 5);
  localparam logic [COL_W-1:0] BELOW_M = COL_W'((1 << TOG_BIT) - 1);
  localparam logic [COL_W-1:0] ABOVE_M = ~COL_W'((1 << (TOG_BIT + 1)) - 1);

  logic              bankQ, hiResQ, fastQ;
  logic [2:0]        acc;
  logic [STEP_W-1:0] idx;
  logic [3:0]        accSum;
  logic              secondHalf, bankBit, activeNow;
  logic [COL_W-1:0]  j, hiLow, colByte;
  logic [ADDR_W-1:0] nextAddr;
  logic              nextEn;

  // Frame-boundary capture of the selection inputs
  always_ff @(posedge clk) begin
    if (rst) begin
      bankQ  <= 1'b0;
      hiResQ <= 1'b0;
      fastQ  <= 1'b0;
    end else if (strobes.frameLatch) begin
      bankQ  <= bankSel;
      hiResQ <= hiResSel;
      fastQ  <= fastSel;
    end
  end

  // Fractional step accumulator: 2/5 or 4/5 steps per clock
  assign accSum = {1'b0, acc} + (hiResQ ? 4'd4 : 4'd2);

  always_ff @(posedge clk) begin
    if (rst || strobes.lineEnd) begin
      acc <= '0;
      idx <= '0;
    end else if (strobes.hActive) begin
      if (accSum >= 4'd5) begin
        acc <= 3'(accSum - 4'd5);
        idx <= idx + STEP_W'(1);
      end else begin
        acc <= accSum[2:0];
      end
    end
  end

  always_comb begin
    activeNow  = strobes.hActive && strobes.vActive;
    secondHalf = hiResQ && (idx >= HALF_C);
    j          = COL_W'(secondHalf ? idx - HALF_C : idx);
    hiLow      = (j & ABOVE_M) | ((j >> 1) & BELOW_M) | (COL_W'(j[0]) << TOG_BIT);
    colByte    = hiResQ ? hiLow : j;
    bankBit    = bankQ ^ secondHalf;
    nextAddr   = activeNow ? {bankBit, rowIdx, colByte} : '0;
    nextEn     = activeNow && !(fastQ && strobes.oddLine);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vgaAddr <= '0;
      colorEn <= 1'b0;
      hsyncN  <= 1'b1;
      vsyncN  <= 1'b1;
    end else begin
      vgaAddr <= nextAddr;
      colorEn <= nextEn;
      hsyncN  <= !strobes.hSyncOn;
      vsyncN  <= !strobes.vSyncOn;
    end
  end

  // R3
  en_blank_chk: assert property (@(posedge clk) disable iff (rst)
    colorEn |-> (hsyncN && vsyncN));

  // R4
  lo_step_chk: assert property (@(posedge clk) disable iff (rst)
    (colorEn && $past(colorEn) && !hiResQ) |->
      (COL_W'(vgaAddr[COL_W-1:0] - $past(vgaAddr[COL_W-1:0])) <= COL_W'(1)));

  // R5
  hi_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (colorEn && $past(colorEn) && hiResQ && (vgaAddr != $past(vgaAddr))) |->
      (vgaAddr[TOG_BIT] != $past(vgaAddr[TOG_BIT])));

  // R6
  fast_odd_chk: assert property (@(posedge clk) disable iff (rst)
    (fastQ && strobes.oddLine) |=> !colorEn);

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(strobes.frameLatch) |-> ($stable(bankQ) && $stable(hiResQ) && $stable(fastQ)));
endmodule

// File: rtl/fb_scan_gen.sv
module fb_scan_gen
  import fb_scan_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int COL_W    = 8,
  parameter int ROW_W    = 8,
  parameter int TOG_BIT  = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bankSel,
  input  logic                  hiResSel,
  input  logic                  fastSel,
  output logic [ROW_W+COL_W:0]  vgaAddr,
  output logic                  colorEn,
  output logic                  hsyncN,
  output logic                  vsyncN
);
  scanStrobes_t     strobes;
  logic [ROW_W-1:0] rowIdx;

  fb_scan_ctrl #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .ROW_W(ROW_W)
  ) ctrl_i (
    .clk(clk), .rst(rst), .strobes(strobes), .rowIdx(rowIdx)
  );

  fb_scan_dpath #(
    .H_ACTIVE(H_ACTIVE), .COL_W(COL_W), .ROW_W(ROW_W), .TOG_BIT(TOG_BIT)
  ) dpath_i (
    .clk(clk), .rst(rst), .strobes(strobes), .rowIdx(rowIdx),
    .bankSel(bankSel), .hiResSel(hiResSel), .fastSel(fastSel),
    .vgaAddr(vgaAddr), .colorEn(colorEn), .hsyncN(hsyncN), .vsyncN(vsyncN)
  );
endmodule

// File: tb/fb_scan_gen_tb_top.sv
module fb_scan_gen_tb_top;
  localparam int HA = 40, HF = 2, HS = 4, HB = 4;
  localparam int VA = 8,  VF = 1, VS = 2, VB = 1;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int HALF = HA * 2 / 5;

  typedef struct {
    logic [16:0] addr;
    logic        en;
    logic        hs;
    logic        vs;
    string       tagA;
    string       tagE;
  } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bankIn = 1'b0, hiIn = 1'b0, fastIn = 1'b0;
  logic [16:0] vgaAddr;
  logic colorEn, hsyncN, vsyncN;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;
  expItem_t q[$];

  int mh = 0, mv = 0;
  bit mBank = 0, mHi = 0, mFast = 0;

  always #2.5 clk = ~clk;

  fb_scan_gen #(
    .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
  ) dut_i (
    .clk(clk), .rst(rst), .bankSel(bankIn), .hiResSel(hiIn), .fastSel(fastIn),
    .vgaAddr(vgaAddr), .colorEn(colorEn), .hsyncN(hsyncN), .vsyncN(vsyncN)
  );

  // Reference model: pushes the expected output for each position
  always @(posedge clk) begin
    if (!rst) begin
      expItem_t e;
      logic [9:0] kk, jj;
      logic [7:0] low;
      bit act, sh;
      act = (mh < HA) && (mv < VA);
      kk = mHi ? 10'((mh * 4) / 5) : 10'((mh * 2) / 5);
      sh = mHi && (kk >= 10'(HALF));
      jj = sh ? kk - 10'(HALF) : kk;
      low = mHi ? {jj[7:4], jj[0], jj[3:1]} : jj[7:0];
      e.addr = act ? {mBank ^ sh, 8'(mv / 2), low} : 17'd0;
      e.en = act && !(mFast && (mv % 2 == 1));
      e.hs = !((mh >= HA + HF) && (mh < HA + HF + HS));
      e.vs = !((mv >= VA + VF) && (mv < VA + VF + VS));
      if (!act) e.tagA = "R9";
      else if ((bankIn != mBank) || (hiIn != mHi)) e.tagA = "R7";
      else if (mHi) e.tagA = "R5";
      else e.tagA = "R4";
      e.tagE = (mFast && (mv % 2 == 1)) ? "R6" : ((fastIn != mFast) ? "R7" : "R3");
      q.push_back(e);
      if (mh == HT - 1 && mv == VA - 1) begin
        mBank = bankIn; mHi = hiIn; mFast = fastIn;
      end
      if (mh == HT - 1) begin
        mh = 0;
        mv = (mv == VT - 1) ? 0 : mv + 1;
      end else begin
        mh = mh + 1;
      end
    end
  end

  // Monitor: compares design outputs against the queued expectations
  always @(negedge clk) begin
    if (q.size() > 0 && !done) begin
      expItem_t e;
      bit bad;
      e = q.pop_front();
      bad = 0;
      tests++;
      if (vgaAddr !== e.addr) begin
        $display("FAIL %s: vgaAddr got %h exp %h", e.tagA, vgaAddr, e.addr); bad = 1;
      end
      if (colorEn !== e.en) begin
        $display("FAIL %s: colorEn got %b exp %b", e.tagE, colorEn, e.en); bad = 1;
      end
      if (hsyncN !== e.hs) begin
        $display("FAIL R1: hsyncN got %b exp %b", hsyncN, e.hs); bad = 1;
      end
      if (vsyncN !== e.vs) begin
        $display("FAIL R2: vsyncN got %b exp %b", vsyncN, e.vs); bad = 1;
      end
      if (bad) fails++;
    end
  end

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: applies selections in mid-frame so captures are exercised
  task automatic setSel(input bit b, input bit h, input bit f);
    bankIn = b; hiIn = h; fastIn = f;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: cycles got %0d exp below %0d", cyc, 20000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    setSel(0, 0, 0);
    waitCycles(3);
    // R8: reset state
    tests++;
    if (vgaAddr !== 17'd0 || colorEn !== 1'b0 || hsyncN !== 1'b1 || vsyncN !== 1'b1) begin
      fails++;
      $display("FAIL R8: reset outputs got %h/%b/%b/%b exp 00000/0/1/1",
               vgaAddr, colorEn, hsyncN, vsyncN);
    end
    rst = 1'b0;
    waitCycles(300);            // frame 0, low-res bank 0
    setSel(1, 0, 0);            // R7: mid-frame change has no effect yet
    waitCycles(600);            // frame 1: bank 1
    setSel(1, 1, 0);            // frame 2: high-res bank 1
    waitCycles(600);
    setSel(0, 0, 1);            // frame 3: fast mode, low-res bank 0
    waitCycles(600);
    setSel(0, 1, 1);            // frame 4: fast mode with high-res
    waitCycles(600);
    setSel(1, 0, 0);            // frame 5: back to plain low-res bank 1
    waitCycles(900);
    waitCycles(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule